// File: doc/BRIEF.md
# Root Port Status Translator

This block turns the raw 32-bit status/control word of one root-hub port into the 32-bit port status word a hub-class driver expects. The low half of the result holds the present status, such as connection, enable, suspend, power and speed. The high half holds the change flags. A mode input picks SuperSpeed reporting or USB 2.0 reporting. The two modes use different bit positions for power and link state. Only SuperSpeed mode carries the link-state-change and warm-reset-change flags.

The translation does more than copy bits. In SuperSpeed mode it hides the controller's internal Resume link state. When the cold-attach flag is set, it reports compliance mode together with a connection, so the hub logic will reset the port. In USB 2.0 mode it derives suspend and L1 from the link state. Two side inputs come from the caller: a pending suspend-change flag and a flag that says the port was suspended. A raw word of all ones marks an absent port. That result is flagged as not present and carries no status.

The block works one request at a time. A one-cycle request pulse captures the inputs, and the registered result appears on the next cycle qualified by a valid strobe. The result stays in place until the next request.

Top module: `root_port_xlate`

## Requirements
- R1: A request sampled at a clock edge sets rspValid for exactly the following cycle, with the result on portStatus. With no request, rspValid is 0 and portStatus keeps its last value. After reset, rspValid, rspPresent and portStatus are all 0.
- R2: Raw change bits map to output change flags in both modes: connect change (raw 17) to output 16, enable change (raw 18) to 17, over-current change (raw 20) to 19, and reset change (raw 21) to 20. In SuperSpeed mode only, link-state change (raw 22) maps to 22 and warm-reset change (raw 19) maps to 21. In USB 2.0 mode, output bits 21 and 22 are 0.
- R3: Output bit 18 (suspend change) is set when suspChange is 1. In USB 2.0 mode it is also set when the link field (raw 8:5) is U0 (0), port power (raw 9) is 1 and suspended is 1.
- R4: In USB 2.0 mode, output bit 2 (suspend) is set when the link field is U3 (3) and port power is 1. In SuperSpeed mode, bit 2 is 0.
- R5: In USB 2.0 mode, output bit 5 (L1) is set when the link field equals U2 (2). Output bits 7:6 are 0.
- R6: In SuperSpeed mode, output bits 8:5 carry the raw link field, except that the internal Resume encoding (15) is reported as 0 and then causes no further rewriting.
- R7: In SuperSpeed mode, when cold-attach (raw 24) is 1 and the link field is not Resume, connection (output 0) is reported. The link field is reported as compliance (10) unless it is already compliance or inactive (6), in which case it is copied.
- R8: In SuperSpeed mode, a link field of compliance (10) reports connection (output 0) even with cold-attach at 0 and the raw connect bit at 0.
- R9: When raw connect (bit 0) is 1, output bit 0 is set. If the speed field (raw 13:10) is 2 (low), output bit 9 is also set. If it is 3 (high), output bit 10 is set. Any other speed adds no flag.
- R10: Raw enable (1), over-current (3) and reset (4) are copied to output bits 1, 3 and 4. Output bits 15:11 and 31:23 are 0.
- R11: Port power (raw 9) appears at output bit 9 in SuperSpeed mode and at output bit 8 in USB 2.0 mode.
- R12: A raw word of all ones gives rspPresent = 0 and portStatus = 0. Any other word gives rspPresent = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle request to translate the current inputs |
| ssMode | input | 1 | 1 = SuperSpeed reporting, 0 = USB 2.0 reporting |
| rawStatus | input | 32 | Raw port status/control word |
| suspChange | input | 1 | Pending suspend-change flag for this port |
| suspended | input | 1 | Port was previously put in suspend |
| rspValid | output | 1 | Result valid, one cycle after a request |
| rspPresent | output | 1 | 0 when the raw word marked the port absent |
| portStatus | output | 32 | Hub-class status (15:0) and change flags (31:16) |

## Verification
The assertions assume that reqValid is a clean single-cycle strobe. They also assume that rawStatus, ssMode and the two side flags are stable while it is sampled. Apart from that, they place no limit on the raw word, because every encoding has a defined result. The stimulus drives all inputs only on the falling edge. It mixes directed words for each link-state case with random words whose link field is biased toward U0, U2, U3, Resume, inactive and compliance. An all-ones word appears about once in sixteen requests, and idle cycles are placed between requests so that the hold behaviour is also checked.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int RAW_W  = 32;
  localparam int PLS_W  = 4;
  localparam int SPD_W  = 4;

  // raw word fields
  localparam int RB_CONN  = 0;
  localparam int RB_ENA   = 1;
  localparam int RB_OVC   = 3;
  localparam int RB_RST   = 4;
  localparam int RB_PLS   = 5;
  localparam int RB_PWR   = 9;
  localparam int RB_SPD   = 10;
  localparam int RB_CCONN = 17;
  localparam int RB_CENA  = 18;
  localparam int RB_CWARM = 19;
  localparam int RB_COVC  = 20;
  localparam int RB_CRST  = 21;
  localparam int RB_CLINK = 22;
  localparam int RB_COLD  = 24;

  // hub-class result fields
  localparam int OB_CONN   = 0;
  localparam int OB_ENA    = 1;
  localparam int OB_SUSP   = 2;
  localparam int OB_OVC    = 3;
  localparam int OB_RST    = 4;
  localparam int OB_L1     = 5;
  localparam int OB_LINK   = 5;
  localparam int OB_PWR2   = 8;
  localparam int OB_PWR3   = 9;
  localparam int OB_LOWSPD = 9;
  localparam int OB_HISPD  = 10;
  localparam int OB_CCONN  = 16;
  localparam int OB_CENA   = 17;
  localparam int OB_CSUSP  = 18;
  localparam int OB_COVC   = 19;
  localparam int OB_CRST   = 20;
  localparam int OB_CWARM  = 21;
  localparam int OB_CLINK  = 22;

  // link state encodings
  localparam logic [PLS_W-1:0] LS_U0       = 4'd0;
  localparam logic [PLS_W-1:0] LS_U2       = 4'd2;
  localparam logic [PLS_W-1:0] LS_U3       = 4'd3;
  localparam logic [PLS_W-1:0] LS_INACTIVE = 4'd6;
  localparam logic [PLS_W-1:0] LS_COMPLY   = 4'd10;
  localparam logic [PLS_W-1:0] LS_RESUME   = 4'd15;

  localparam logic [SPD_W-1:0] SPD_LOW  = 4'd2;
  localparam logic [SPD_W-1:0] SPD_HIGH = 4'd3;

  typedef struct packed {
    logic capture;
    logic present;
    logic ssMode;
  } ctlStrobe_t;
endpackage

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             ssMode,
  input  logic [RAW_W-1:0] rawStatus,
  output ctlStrobe_t       strobe,
  output logic             rspValid,
  output logic             rspPresent
);
  localparam logic [RAW_W-1:0] ABSENT_WORD = '1;

  logic isPresent;
  assign isPresent = (rawStatus != ABSENT_WORD);

  always_comb begin
    strobe.capture = reqValid;
    strobe.present = isPresent;
    strobe.ssMode  = ssMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspPresent <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rspPresent <= isPresent;
    end
  end
endmodule

// File: rtl/ptx_ss_link.sv
module ptx_ss_link
  import ptx_pkg::*;
(
  input  logic [PLS_W-1:0] linkIn,
  input  logic             coldAttach,
  output logic [PLS_W-1:0] linkOut,
  output logic             forceConn
);
  // priority: hidden resume, then cold-attach, then plain compliance
  always_comb begin
    linkOut   = linkIn;
    forceConn = 1'b0;
    if (linkIn == LS_RESUME) begin
      linkOut = '0;
    end else if (coldAttach) begin
      forceConn = 1'b1;
      if (linkIn != LS_COMPLY && linkIn != LS_INACTIVE) linkOut = LS_COMPLY;
    end else if (linkIn == LS_COMPLY) begin
      forceConn = 1'b1;
    end
  end
endmodule

// File: rtl/ptx_datapath.sv
module ptx_datapath
  import ptx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic [RAW_W-1:0] rawStatus,
  input  logic             suspChange,
  input  logic             suspended,
  output logic [RAW_W-1:0] portStatus
);
  logic [PLS_W-1:0] linkIn;
  logic [SPD_W-1:0] speed;
  logic             power;
  logic [PLS_W-1:0] ssLink;
  logic             ssForceConn;
  logic [RAW_W-1:0] nextStatus;
  logic             unusedBits;

  assign linkIn = rawStatus[RB_PLS +: PLS_W];
  assign speed  = rawStatus[RB_SPD +: SPD_W];
  assign power  = rawStatus[RB_PWR];
  assign unusedBits = ^{rawStatus[RAW_W-1:RB_COLD+1], rawStatus[RB_COLD-1],
                        rawStatus[RB_CCONN-1:RB_SPD+SPD_W], rawStatus[2]};

  ptx_ss_link u_ssLink (
    .linkIn     (linkIn),
    .coldAttach (rawStatus[RB_COLD]),
    .linkOut    (ssLink),
    .forceConn  (ssForceConn)
  );

  always_comb begin
    nextStatus = '0;
    // change flags common to both modes
    nextStatus[OB_CCONN] = rawStatus[RB_CCONN];
    nextStatus[OB_CENA]  = rawStatus[RB_CENA];
    nextStatus[OB_COVC]  = rawStatus[RB_COVC];
    nextStatus[OB_CRST]  = rawStatus[RB_CRST];
    // plain status copies
    nextStatus[OB_ENA] = rawStatus[RB_ENA];
    nextStatus[OB_OVC] = rawStatus[RB_OVC];
    nextStatus[OB_RST] = rawStatus[RB_RST];
    // connection and speed
    if (rawStatus[RB_CONN]) begin
      nextStatus[OB_CONN] = 1'b1;
      if (speed == SPD_LOW)       nextStatus[OB_LOWSPD] = 1'b1;
      else if (speed == SPD_HIGH) nextStatus[OB_HISPD]  = 1'b1;
    end
    if (strobe.ssMode) begin
      nextStatus[OB_CLINK] = rawStatus[RB_CLINK];
      nextStatus[OB_CWARM] = rawStatus[RB_CWARM];
      nextStatus[OB_PWR3]  = nextStatus[OB_PWR3] | power;
      nextStatus[OB_LINK +: PLS_W] = ssLink;
      nextStatus[OB_CONN]  = nextStatus[OB_CONN] | ssForceConn;
      nextStatus[OB_CSUSP] = suspChange;
    end else begin
      nextStatus[OB_PWR2]  = power;
      nextStatus[OB_SUSP]  = (linkIn == LS_U3) && power;
      nextStatus[OB_L1]    = (linkIn == LS_U2);
      nextStatus[OB_CSUSP] = suspChange | ((linkIn == LS_U0) && power && suspended);
    end
    if (!strobe.present) nextStatus = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              portStatus <= '0;
    else if (strobe.capture) portStatus <= nextStatus;
  end
endmodule

// File: rtl/root_port_xlate.sv
module root_port_xlate
  import ptx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        ssMode,
  input  logic [31:0] rawStatus,
  input  logic        suspChange,
  input  logic        suspended,
  output logic        rspValid,
  output logic        rspPresent,
  output logic [31:0] portStatus
);
  ctlStrobe_t strobe;

  ptx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .ssMode     (ssMode),
    .rawStatus  (rawStatus),
    .strobe     (strobe),
    .rspValid   (rspValid),
    .rspPresent (rspPresent)
  );

  ptx_datapath u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .rawStatus  (rawStatus),
    .suspChange (suspChange),
    .suspended  (suspended),
    .portStatus (portStatus)
  );
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        ssMode,
  input logic [31:0] rawStatus,
  input logic        suspChange,
  input logic        suspended,
  input logic        rspValid,
  input logic        rspPresent,
  input logic [31:0] portStatus
);
  logic present;
  assign present = (rawStatus != 32'hFFFF_FFFF);

  assert_req_to_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!rspValid && $stable(portStatus)));
  assert_no_ss_change_in_usb2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !ssMode) |=> (portStatus[22:21] == 2'b00));
  assert_susp_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && present && (suspChange || (!ssMode && rawStatus[8:5] == 4'd0 &&
      rawStatus[9] && suspended))) |=> portStatus[18]);
  assert_resume_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ssMode && rawStatus[8:5] == 4'd15 && present) |=> (portStatus[8:5] == 4'd0));
  assert_cold_attach_conn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ssMode && present && rawStatus[24] && rawStatus[8:5] != 4'd15)
      |=> portStatus[0]);
  assert_connect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && present && rawStatus[0]) |=> portStatus[0]);
  assert_ss_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ssMode && present && rawStatus[9]) |=> portStatus[9]);
  assert_absent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !present) |=> (!rspPresent && portStatus == 32'd0));
endmodule

bind root_port_xlate ptx_checker i_ptxChecker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .ssMode     (ssMode),
  .rawStatus  (rawStatus),
  .suspChange (suspChange),
  .suspended  (suspended),
  .rspValid   (rspValid),
  .rspPresent (rspPresent),
  .portStatus (portStatus)
);

// File: tb/test_root_port_xlate.sv
`timescale 1ns/1ps
module test_root_port_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        ssMode = 1'b0;
  logic [31:0] rawStatus = '0;
  logic        suspChange = 1'b0;
  logic        suspended = 1'b0;
  logic        rspValid;
  logic        rspPresent;
  logic [31:0] portStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] expWord = '0;
  logic        expPresent = 1'b0;

  always #10 clk = ~clk;

  root_port_xlate i_root_port_xlate (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .ssMode(ssMode),
    .rawStatus(rawStatus), .suspChange(suspChange), .suspended(suspended),
    .rspValid(rspValid), .rspPresent(rspPresent), .portStatus(portStatus)
  );

  // behavioural model written from the requirement list
  function automatic logic [31:0] model(input logic [31:0] raw, input logic ss,
                                        input logic sc, input logic su);
    logic [31:0] r;
    int pls;
    int spd;
    r = '0;
    if (raw == 32'hFFFF_FFFF) return r;
    pls = int'(raw[8:5]);
    spd = int'(raw[13:10]);
    if (raw[17]) r[16] = 1;                 // R2
    if (raw[18]) r[17] = 1;
    if (raw[20]) r[19] = 1;
    if (raw[21]) r[20] = 1;
    if (ss && raw[22]) r[22] = 1;
    if (ss && raw[19]) r[21] = 1;
    if (sc) r[18] = 1;                      // R3
    if (!ss && pls == 0 && raw[9] && su) r[18] = 1;
    if (raw[0]) begin                       // R9
      r[0] = 1;
      if (spd == 2) r[9] = 1;
      else if (spd == 3) r[10] = 1;
    end
    r[1] = raw[1]; r[3] = raw[3]; r[4] = raw[4];   // R10
    if (ss) begin
      if (raw[9]) r[9] = 1;                 // R11
      if (pls != 15) begin                  // R6
        if (raw[24]) begin                  // R7
          r[0] = 1;
          r[8:5] = (pls == 10 || pls == 6) ? raw[8:5] : 4'd10;
        end else begin
          r[8:5] = raw[8:5];
          if (pls == 10) r[0] = 1;          // R8
        end
      end
    end else begin
      r[8] = raw[9];                        // R11
      if (pls == 3 && raw[9]) r[2] = 1;     // R4
      if (pls == 2) r[5] = 1;               // R5
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareResult(input logic [31:0] raw, input logic ss);
    string linkTag;
    string connTag;
    int pls;
    pls = int'(raw[8:5]);
    linkTag = "R6";
    connTag = "R9";
    if (ss && pls != 15 && raw[24]) begin linkTag = "R7"; connTag = "R7"; end
    else if (ss && pls == 10) begin linkTag = "R8"; connTag = "R8"; end
    check("R12 present", {31'd0, rspPresent}, {31'd0, expPresent});
    if (!expPresent) begin
      check("R12 absent word", portStatus, 32'd0);
      return;
    end
    check("R2 change flags", portStatus & 32'hFFFB_0000, expWord & 32'hFFFB_0000);
    check("R3 suspend change", portStatus & 32'h0004_0000, expWord & 32'h0004_0000);
    check({connTag, " connection"}, portStatus & 32'h1, expWord & 32'h1);
    check("R10 copied bits", portStatus & 32'hF81A, expWord & 32'hF81A);
    check("R4 suspend", portStatus & 32'h4, expWord & 32'h4);
    check("R9 high speed", portStatus & 32'h400, expWord & 32'h400);
    if (ss) begin
      check({linkTag, " link field"}, portStatus & 32'h1E0, expWord & 32'h1E0);
      check("R11 ss power/low speed", portStatus & 32'h200, expWord & 32'h200);
    end else begin
      check("R5 L1 field", portStatus & 32'hE0, expWord & 32'hE0);
      check("R11 usb2 power", portStatus & 32'h100, expWord & 32'h100);
      check("R9 low speed", portStatus & 32'h200, expWord & 32'h200);
    end
  endtask

  // one request cycle: drive at falling edge, compare at the next one
  task automatic request(input logic [31:0] raw, input logic ss,
                         input logic sc, input logic su);
    reqValid = 1'b1; rawStatus = raw; ssMode = ss; suspChange = sc; suspended = su;
    expWord = model(raw, ss, sc, su);
    expPresent = (raw != 32'hFFFF_FFFF);
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 valid after request", {31'd0, rspValid}, 32'd1);
    compareResult(raw, ss);
  endtask

  task automatic idle(input logic [31:0] raw);
    reqValid = 1'b0; rawStatus = raw; ssMode = ~ssMode;
    @(negedge clk);
    check("R1 no valid when idle", {31'd0, rspValid}, 32'd0);
    check("R1 held result", portStatus, expWord);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, rspValid}, 32'd0);
    check("R1 reset present", {31'd0, rspPresent}, 32'd0);
    check("R1 reset status", portStatus, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed cases
    request(32'h0000_0E03 | (32'd3 << 10), 1'b0, 1'b0, 1'b0);   // R9 high speed, R11 usb2 power
    request(32'h0000_0A01 | (32'd3 << 5),  1'b0, 1'b0, 1'b0);   // R4 suspend at U3, R9 low speed
    request(32'h0000_0040, 1'b0, 1'b0, 1'b0);                   // R5 L1 at U2
    request(32'h0000_0200, 1'b0, 1'b0, 1'b1);                   // R3 U0+power+suspended
    idle(32'h1234_5678);
    request(32'h007E_0000, 1'b0, 1'b0, 1'b0);                   // R2 usb2 drops 21/22
    request(32'h007E_0000, 1'b1, 1'b1, 1'b0);                   // R2 ss, R3 flag
    request(32'h0000_0201 | (32'd15 << 5), 1'b1, 1'b0, 1'b0);   // R6 resume hidden
    request(32'h0100_0000 | (32'd15 << 5), 1'b1, 1'b0, 1'b0);   // R6 resume beats cold-attach
    request(32'h0100_0000 | (32'd5 << 5),  1'b1, 1'b0, 1'b0);   // R7 rewritten to compliance
    request(32'h0100_0000 | (32'd6 << 5),  1'b1, 1'b0, 1'b0);   // R7 inactive copied
    request(32'h0000_0000 | (32'd10 << 5), 1'b1, 1'b0, 1'b0);   // R8 compliance connect
    request(32'h0000_001A, 1'b1, 1'b0, 1'b0);                   // R10 copies
    idle(32'hFFFF_FFFF);
    request(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);                   // R12 absent
    request(32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1);                   // R12 absent usb2
    request(32'h0000_0001, 1'b1, 1'b0, 1'b0);                   // R12 present again
    // random sweep with biased link field
    for (int i = 0; i < 600; i++) begin
      logic [31:0] raw;
      int pick;
      raw = $urandom;
      pick = int'($urandom_range(0, 7));
      case (pick)
        0: raw[8:5] = 4'd0;
        1: raw[8:5] = 4'd2;
        2: raw[8:5] = 4'd3;
        3: raw[8:5] = 4'd6;
        4: raw[8:5] = 4'd10;
        5: raw[8:5] = 4'd15;
        default: ;
      endcase
      if ($urandom_range(0, 15) == 0) raw = 32'hFFFF_FFFF;
      request(raw, 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom);
    end
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule